// File: doc/BRIEF.md
# Synchronous Burst SRAM Controller

This block converts single-word requests from an internal valid/ready port into bus cycles for an external synchronous burst SRAM. Each accepted request becomes exactly one bus word in the clock cycle after the acceptance edge. All external outputs are registered, so they change only on the rising clock edge. All strobes are active low.

Writes strobe the address on every word. Reads strobe the address only at the start of a run, on a break in the sequence, or when the address returns to offset zero of a four-word group. In every other read cycle the controller pulses the advance strobe, and the memory's internal counter moves to the next word. A read run that starts at offset k within a group therefore lasts at most 4−k words before the controller strobes again. Read data is captured from the bus two clock edges after the read bus cycle. It is returned with the word address it belongs to, in request order.

The sequencer has four states. ST_IDLE drives no bus cycle. ST_READ drives a read word. ST_WRITE drives a write word. ST_TURN is a dead cycle between a read and a following write. The transitions are:
- **go_read**: any state goes to ST_READ on a valid read request.
- **go_write**: ST_IDLE, ST_WRITE or ST_TURN goes to ST_WRITE on a valid write request.
- **turn**: ST_READ goes to ST_TURN on a valid write request. That request is held off for one cycle.
- **rest**: any state goes to ST_IDLE when no request is valid.

Top module: `sbsram_ctrl`

## Requirements
- R1: While reset is held and just after it, mem_ce_n, mem_ads_n, mem_adv_n, mem_oe_n and mem_we_n are 1, mem_be_n is all ones, mem_dq_oe is 0 and rd_valid is 0.
- R2: A request accepted at a rising edge (req_valid and req_ready both 1) produces its bus word in the cycle that starts at that edge. No other bus words are produced.
- R3: A write word drives mem_ce_n=0, mem_ads_n=0, mem_we_n=0, mem_adv_n=1 and mem_oe_n=1. It puts the request address on mem_addr and the write data on mem_dq_out, drives mem_dq_oe=1, and sets mem_be_n to the bitwise inverse of req_be (bit i low means byte i is written).
- R4: A read word drives mem_ads_n=0 with the request address on mem_addr if any of these is true: the previous bus cycle was not a read, the address is not the previous read address plus one, or the address bits [1:0] are 00.
- R5: Any other read word drives mem_adv_n=0 and mem_ads_n=1, with mem_addr unchanged. A run that starts at offset k in a four-word group therefore has at most 4−k words per strobe.
- R6: mem_ads_n and mem_adv_n are never both 0. mem_adv_n is 0 only in read words.
- R7: mem_oe_n is 0 exactly in read words, with mem_ce_n=0 and mem_be_n all zeros. mem_we_n is 0 only in write words. mem_dq_oe is 1 only in write words.
- R8: If a write request is presented while the current bus cycle is a read, req_ready is 0 for one cycle. That cycle is followed by one bus cycle with all strobes high and mem_dq_oe=0, and then the write is accepted.
- R9: For a read word driven in the cycle after edge n, rd_valid is 1 after edge n+2. rd_data is mem_dq_in as sampled at edge n+2, rd_addr is the request address, and responses come back in request order.
- R10: A cycle with no accepted request keeps all strobes high, mem_be_n all ones and mem_dq_oe 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock; all outputs change on its rising edge |
| rst | input | 1 | Synchronous reset, active high |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request accepted at the next edge when high |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | AW | Word address |
| req_wdata | input | DW | Write data |
| req_be | input | DW/8 | Write byte enables, active high |
| rd_valid | output | 1 | Read response valid |
| rd_addr | output | AW | Word address of the response |
| rd_data | output | DW | Read data |
| mem_ce_n | output | 1 | Memory chip enable, active low |
| mem_be_n | output | DW/8 | Memory byte enables, active low |
| mem_addr | output | AW | Memory address |
| mem_dq_out | output | DW | Data driven toward memory |
| mem_dq_oe | output | 1 | Data bus drive enable |
| mem_dq_in | input | DW | Data received from memory |
| mem_ads_n | output | 1 | Address strobe, active low |
| mem_adv_n | output | 1 | Address advance, active low |
| mem_oe_n | output | 1 | Memory output enable, active low |
| mem_we_n | output | 1 | Memory write enable, active low |

## Verification
- **Bus strobes and address:** these are due one edge after the request is accepted. The driver task waits for that edge and reads them at the following falling edge. It compares them with strobe decisions it derives itself from its own record of the previous word.
- **Turnaround:** the idle cycle is checked one edge after the refused write, and the write's own bus word one edge after that.
- **Read responses:** these are due two edges after the read bus word. The driver stamps each expected response with that cycle number. The monitor flags a response that is early, late, out of order or carries wrong data.
- **Bus model:** the bench models the memory's own address counter, so a missing or misplaced strobe also shows up as wrong read data.

// File: rtl/sbsram_pkg.sv
package sbsram_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_READ  = 2'd1,
        ST_WRITE = 2'd2,
        ST_TURN  = 2'd3
    } bus_state_e;

endpackage

// File: rtl/sbsram_burst_track.sv
// Decides whether a read word needs a fresh address strobe or may advance.
module sbsram_burst_track #(
    parameter int AW       = 16,
    parameter int GRP_BITS = 2
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          rd_issue,
    input  logic [AW-1:0] rd_addr,
    input  logic          bus_was_read,
    output logic          restrobe
);
    logic [AW-1:0] last_q;
    logic          in_seq;
    logic          grp_start;

    assign in_seq    = (rd_addr == last_q + AW'(1));
    assign grp_start = (rd_addr[GRP_BITS-1:0] == '0);
    assign restrobe  = !bus_was_read || !in_seq || grp_start;

    always_ff @(posedge clk) begin
        if (rst)
            last_q <= '0;
        else if (rd_issue)
            last_q <= rd_addr;
    end

endmodule

// File: rtl/sbsram_rd_pipe.sv
// Carries read tags through the fixed memory latency and captures data.
module sbsram_rd_pipe #(
    parameter int AW  = 16,
    parameter int DW  = 32,
    parameter int LAT = 2
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          issue,
    input  logic [AW-1:0] issue_addr,
    input  logic [DW-1:0] dq_in,
    output logic          rd_valid,
    output logic [AW-1:0] rd_addr,
    output logic [DW-1:0] rd_data
);
    logic [LAT-1:0] vld_q;
    logic [AW-1:0]  tag_q [LAT];

    for (genvar g = 0; g < LAT; g++) begin : g_stage
        if (g == 0) begin : g_head
            always_ff @(posedge clk) begin
                if (rst) vld_q[0] <= 1'b0;
                else     vld_q[0] <= issue;
                tag_q[0] <= issue_addr;
            end
        end else begin : g_body
            always_ff @(posedge clk) begin
                if (rst) vld_q[g] <= 1'b0;
                else     vld_q[g] <= vld_q[g-1];
                tag_q[g] <= tag_q[g-1];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_valid <= 1'b0;
            rd_addr  <= '0;
            rd_data  <= '0;
        end else begin
            rd_valid <= vld_q[LAT-1];
            if (vld_q[LAT-1]) begin
                rd_addr <= tag_q[LAT-1];
                rd_data <= dq_in;
            end
        end
    end

endmodule

// File: rtl/sbsram_ctrl.sv
module sbsram_ctrl
    import sbsram_pkg::*;
#(
    parameter int AW       = 16,
    parameter int DW       = 32,
    parameter int RD_LAT   = 2,
    parameter int GRP_BITS = 2,
    localparam int BW      = DW / 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          req_valid,
    output logic          req_ready,
    input  logic          req_write,
    input  logic [AW-1:0] req_addr,
    input  logic [DW-1:0] req_wdata,
    input  logic [BW-1:0] req_be,
    output logic          rd_valid,
    output logic [AW-1:0] rd_addr,
    output logic [DW-1:0] rd_data,
    output logic          mem_ce_n,
    output logic [BW-1:0] mem_be_n,
    output logic [AW-1:0] mem_addr,
    output logic [DW-1:0] mem_dq_out,
    output logic          mem_dq_oe,
    input  logic [DW-1:0] mem_dq_in,
    output logic          mem_ads_n,
    output logic          mem_adv_n,
    output logic          mem_oe_n,
    output logic          mem_we_n
);
    bus_state_e state_q, state_d;
    logic       restrobe;
    logic       rd_issue;

    // a write right after a read word must wait out one dead cycle
    assign req_ready = !(state_q == ST_READ && req_valid && req_write);
    assign rd_issue  = (state_d == ST_READ);

    always_comb begin
        state_d = ST_IDLE;
        unique case (state_q)
            ST_READ:
                if (req_valid) state_d = req_write ? ST_TURN : ST_READ;
            ST_IDLE, ST_WRITE, ST_TURN:
                if (req_valid) state_d = req_write ? ST_WRITE : ST_READ;
            default:
                state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) state_q <= ST_IDLE;
        else     state_q <= state_d;
    end

    sbsram_burst_track #(
        .AW       (AW),
        .GRP_BITS (GRP_BITS)
    ) u_track (
        .clk          (clk),
        .rst          (rst),
        .rd_issue     (rd_issue),
        .rd_addr      (req_addr),
        .bus_was_read (state_q == ST_READ),
        .restrobe     (restrobe)
    );

    // registered bus outputs, chosen by the state being entered
    always_ff @(posedge clk) begin
        if (rst) begin
            mem_ce_n   <= 1'b1;
            mem_be_n   <= '1;
            mem_addr   <= '0;
            mem_dq_out <= '0;
            mem_dq_oe  <= 1'b0;
            mem_ads_n  <= 1'b1;
            mem_adv_n  <= 1'b1;
            mem_oe_n   <= 1'b1;
            mem_we_n   <= 1'b1;
        end else begin
            mem_ce_n  <= 1'b1;
            mem_be_n  <= '1;
            mem_dq_oe <= 1'b0;
            mem_ads_n <= 1'b1;
            mem_adv_n <= 1'b1;
            mem_oe_n  <= 1'b1;
            mem_we_n  <= 1'b1;
            unique case (state_d)
                ST_READ: begin
                    mem_ce_n <= 1'b0;
                    mem_oe_n <= 1'b0;
                    mem_be_n <= '0;
                    if (restrobe) begin
                        mem_ads_n <= 1'b0;
                        mem_addr  <= req_addr;
                    end else begin
                        mem_adv_n <= 1'b0;
                    end
                end
                ST_WRITE: begin
                    mem_ce_n   <= 1'b0;
                    mem_we_n   <= 1'b0;
                    mem_ads_n  <= 1'b0;
                    mem_addr   <= req_addr;
                    mem_be_n   <= ~req_be;
                    mem_dq_out <= req_wdata;
                    mem_dq_oe  <= 1'b1;
                end
                ST_IDLE, ST_TURN: begin
                end
                default: begin
                end
            endcase
        end
    end

    sbsram_rd_pipe #(
        .AW  (AW),
        .DW  (DW),
        .LAT (RD_LAT)
    ) u_rd_pipe (
        .clk        (clk),
        .rst        (rst),
        .issue      (rd_issue),
        .issue_addr (req_addr),
        .dq_in      (mem_dq_in),
        .rd_valid   (rd_valid),
        .rd_addr    (rd_addr),
        .rd_data    (rd_data)
    );

endmodule

// File: rtl/sbsram_ctrl_chk.sv
module sbsram_ctrl_chk #(
    parameter int AW = 16,
    parameter int DW = 32,
    localparam int BW = DW / 8
) (
    input logic          clk,
    input logic          rst,
    input logic          rd_valid,
    input logic          mem_ce_n,
    input logic [BW-1:0] mem_be_n,
    input logic [AW-1:0] mem_addr,
    input logic          mem_dq_oe,
    input logic          mem_ads_n,
    input logic          mem_adv_n,
    input logic          mem_oe_n,
    input logic          mem_we_n
);
    p_write_ads_r3: assert property (@(posedge clk) disable iff (rst)
        !mem_we_n |-> (!mem_ads_n && !mem_ce_n && mem_dq_oe && mem_adv_n));

    p_adv_hold_r5: assert property (@(posedge clk) disable iff (rst)
        !mem_adv_n |-> ($stable(mem_addr) && !mem_oe_n));

    p_adv_after_read_r5: assert property (@(posedge clk) disable iff (rst)
        !mem_adv_n |-> $past(!mem_oe_n));

    p_strobe_excl_r6: assert property (@(posedge clk) disable iff (rst)
        !(!mem_ads_n && !mem_adv_n));

    p_no_rd_wr_r7: assert property (@(posedge clk) disable iff (rst)
        !(!mem_oe_n && !mem_we_n));

    p_drive_write_r7: assert property (@(posedge clk) disable iff (rst)
        mem_dq_oe |-> !mem_we_n);

    p_turn_gap_r8: assert property (@(posedge clk) disable iff (rst)
        !mem_oe_n |=> mem_we_n);

    p_rd_lat_r9: assert property (@(posedge clk) disable iff (rst)
        (!mem_oe_n && !mem_ce_n) |=> ##1 rd_valid);

    p_idle_quiet_r10: assert property (@(posedge clk) disable iff (rst)
        mem_ce_n |-> (mem_ads_n && mem_adv_n && mem_oe_n && mem_we_n
                      && !mem_dq_oe && (mem_be_n == '1)));

endmodule

bind sbsram_ctrl sbsram_ctrl_chk #(.AW(AW), .DW(DW)) u_chk (.*);

// File: tb/sbsram_ctrl_tb.sv
`timescale 1ns/1ps
module sbsram_ctrl_tb;
    localparam int AW = 16;
    localparam int DW = 32;
    localparam int BW = DW / 8;

    logic          clk = 1'b0;
    logic          rst;
    logic          req_valid, req_ready, req_write;
    logic [AW-1:0] req_addr;
    logic [DW-1:0] req_wdata;
    logic [BW-1:0] req_be;
    logic          rd_valid;
    logic [AW-1:0] rd_addr;
    logic [DW-1:0] rd_data;
    logic          mem_ce_n, mem_dq_oe, mem_ads_n, mem_adv_n, mem_oe_n, mem_we_n;
    logic [BW-1:0] mem_be_n;
    logic [AW-1:0] mem_addr;
    logic [DW-1:0] mem_dq_out, mem_dq_in;

    always #4 clk = ~clk;

    sbsram_ctrl #(.AW(AW), .DW(DW)) u_dut (
        .clk(clk), .rst(rst),
        .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata), .req_be(req_be),
        .rd_valid(rd_valid), .rd_addr(rd_addr), .rd_data(rd_data),
        .mem_ce_n(mem_ce_n), .mem_be_n(mem_be_n), .mem_addr(mem_addr),
        .mem_dq_out(mem_dq_out), .mem_dq_oe(mem_dq_oe), .mem_dq_in(mem_dq_in),
        .mem_ads_n(mem_ads_n), .mem_adv_n(mem_adv_n), .mem_oe_n(mem_oe_n),
        .mem_we_n(mem_we_n)
    );

    // ---- memory model with its own burst counter ----
    logic [DW-1:0] mem_arr [256];
    logic [DW-1:0] shadow  [256];
    logic [AW-1:0] ictr;
    logic [AW-1:0] a_now;
    logic [DW-1:0] q_reg;
    assign mem_dq_in = q_reg;

    always @(posedge clk) begin
        if (!mem_ce_n && !mem_ads_n && !mem_we_n && mem_dq_oe)
            for (int b = 0; b < BW; b++)
                if (!mem_be_n[b]) mem_arr[mem_addr[7:0]][b*8 +: 8] <= mem_dq_out[b*8 +: 8];
        if (!mem_ce_n && !mem_oe_n) begin
            a_now = !mem_ads_n ? mem_addr : {ictr[AW-1:2], ictr[1:0] + 2'd1};
            ictr  <= a_now;
            q_reg <= mem_arr[a_now[7:0]];
        end
    end

    // ---- bookkeeping ----
    int checks = 0;
    int errors = 0;
    int cyc    = 0;
    bit done   = 0;
    always @(posedge clk) cyc <= cyc + 1;

    typedef struct { logic [AW-1:0] a; logic [DW-1:0] d; int due; } exp_t;
    exp_t exp_q[$];

    logic          prev_rd;
    logic [AW-1:0] prev_addr;
    logic [AW-1:0] strobe_addr;

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h (cycle %0d)", req, act, exp, cyc);
        end
    endtask

    task automatic check_quiet(input string req);
        chk(mem_ce_n && mem_ads_n && mem_adv_n && mem_oe_n && mem_we_n
            && !mem_dq_oe && (mem_be_n == '1), req,
            {mem_ce_n, mem_ads_n, mem_adv_n, mem_oe_n, mem_we_n, mem_dq_oe, mem_be_n},
            {6'b111110, {BW{1'b1}}});
    endtask

    // called just after a falling edge; returns at the falling edge after the bus word
    task automatic issue(input bit wr, input logic [AW-1:0] addr, input logic [DW-1:0] wd,
                         input logic [BW-1:0] be);
        bit exp_ads;
        req_valid = 1'b1; req_write = wr; req_addr = addr; req_wdata = wd; req_be = be;
        #1;
        if (wr && prev_rd) begin
            chk(req_ready == 1'b0, "R8 ready low after read", req_ready, 0);
            @(posedge clk); @(negedge clk);
            check_quiet("R8 dead cycle");
            prev_rd = 1'b0;
            #1;
        end
        chk(req_ready == 1'b1, "R2 ready", req_ready, 1);
        @(posedge clk); @(negedge clk);
        if (wr) begin
            chk(!mem_ce_n && !mem_ads_n && !mem_we_n && mem_adv_n && mem_oe_n,
                "R3 write strobes", {mem_ce_n, mem_ads_n, mem_adv_n, mem_oe_n, mem_we_n}, 5'b00110);
            chk(mem_addr == addr && mem_dq_out == wd && mem_dq_oe, "R3 write addr/data",
                {mem_addr, mem_dq_out}, {addr, wd});
            chk(mem_be_n == ~be, "R3 byte enables", mem_be_n, ~be);
            for (int b = 0; b < BW; b++)
                if (be[b]) shadow[addr[7:0]][b*8 +: 8] = wd[b*8 +: 8];
            prev_rd = 1'b0;
        end else begin
            exp_ads = !prev_rd || (addr != prev_addr + AW'(1)) || (addr[1:0] == 2'b00);
            chk(mem_ads_n == !exp_ads && mem_adv_n == exp_ads,
                exp_ads ? "R4 strobe expected" : "R5 advance expected",
                {mem_ads_n, mem_adv_n}, {!exp_ads, exp_ads});
            chk(!mem_ce_n && !mem_oe_n && mem_we_n && !mem_dq_oe && mem_be_n == '0,
                "R7 read controls", {mem_ce_n, mem_oe_n, mem_we_n, mem_dq_oe}, 4'b0010);
            if (exp_ads) begin
                chk(mem_addr == addr, "R4 strobed address", mem_addr, addr);
                strobe_addr = addr;
            end else begin
                chk(mem_addr == strobe_addr, "R5 address held", mem_addr, strobe_addr);
            end
            exp_q.push_back('{a: addr, d: shadow[addr[7:0]], due: cyc + 2});
            prev_rd   = 1'b1;
            prev_addr = addr;
        end
    endtask

    task automatic idle_cycle();
        req_valid = 1'b0;
        @(posedge clk); @(negedge clk);
        check_quiet("R10 idle");
        prev_rd = 1'b0;
    endtask

    // ---- response monitor ----
    always @(negedge clk) begin
        if (!rst && !done) begin
            if (rd_valid) begin
                if (exp_q.size() == 0) begin
                    chk(1'b0, "R9 unexpected response", rd_addr, 0);
                end else begin
                    exp_t e;
                    e = exp_q.pop_front();
                    chk(cyc == e.due, "R9 latency", cyc, e.due);
                    chk(rd_addr == e.a, "R9 tag", rd_addr, e.a);
                    chk(rd_data == e.d, "R9 data", rd_data, e.d);
                end
            end else if (exp_q.size() > 0 && exp_q[0].due <= cyc) begin
                chk(1'b0, "R9 response missing", cyc, exp_q[0].due);
                void'(exp_q.pop_front());
            end
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 256; i++) begin
            mem_arr[i] = 32'hC3A50000 ^ (i * 32'h00010101);
            shadow[i]  = mem_arr[i];
        end
        ictr = '0; q_reg = '0;
        prev_rd = 1'b0; prev_addr = '0; strobe_addr = '0;
        rst = 1'b1; req_valid = 1'b0; req_write = 1'b0;
        req_addr = '0; req_wdata = '0; req_be = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        check_quiet("R1 in reset");
        chk(rd_valid == 1'b0, "R1 rd_valid in reset", rd_valid, 0);
        rst = 1'b0;
        @(negedge clk);
        check_quiet("R1 after reset");

        // full aligned group, then wrap into the next group
        issue(0, 16'h0000, '0, '0);
        issue(0, 16'h0001, '0, '0);
        issue(0, 16'h0002, '0, '0);
        issue(0, 16'h0003, '0, '0);
        issue(0, 16'h0004, '0, '0);
        // run from offset 2: two words, then a new strobe
        issue(0, 16'h0006, '0, '0);
        issue(0, 16'h0007, '0, '0);
        issue(0, 16'h0008, '0, '0);
        // sequence break
        issue(0, 16'h0014, '0, '0);
        issue(0, 16'h0019, '0, '0);
        // read then write: dead cycle
        issue(1, 16'h0021, 32'h11223344, 4'b1111);
        issue(1, 16'h0022, 32'hAABBCCDD, 4'b0101);
        issue(1, 16'h0023, 32'h55667788, 4'b1000);
        // write to read needs no gap
        issue(0, 16'h0021, '0, '0);
        issue(0, 16'h0022, '0, '0);
        issue(0, 16'h0023, '0, '0);
        idle_cycle();
        // sequential address after an idle cycle still strobes
        issue(0, 16'h0024, '0, '0);
        issue(0, 16'h0025, '0, '0);
        idle_cycle();
        idle_cycle();
        idle_cycle();
        chk(exp_q.size() == 0, "R9 all responses returned", exp_q.size(), 0);

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule